// File: doc/BRIEF.md
# Two-Dimensional Cellular Automaton Random Bit Generator

This block is a rectangular grid of one-bit cells. Together they produce one pseudo-random bit stream per cell, and each stream is meant to be 1 about half of the time. It is meant for stochastic arithmetic, where a value is carried as the density of ones in a bit stream. Such a datapath needs many parallel streams that are weakly correlated, and it cannot afford a separate wide generator for each stream.

On every enabled clock, all cells update at once from the previous cycle's grid. Each cell combines its own bit with the bit of the cell above it and the bit of the cell to its left. The edges wrap around, so the grid behaves as a torus. A two-bit input selects one of three combining rules. A synchronous load writes a seed into every cell. A seed of all zeros is replaced by a fixed pattern, because a grid of all zeros would never leave that state under some of the rules.

Top module: `ca_rng_array`

## Requirements
- R1: After reset the grid holds the fixed pattern, in which cell index 0 is 1 and every other cell is 0. Cell (row r, column c) is bit r*COLS+c of `bits_o`.
- R2: When `load_i` is high and `seed_i` is nonzero, the grid equals `seed_i` after the next clock edge. This happens whatever the values of `en_i` and `rule_i`.
- R3: When `load_i` is high and `seed_i` is all zeros, the grid holds the fixed pattern of R1 after the next clock edge.
- R4: When `load_i` and `en_i` are both low, the grid keeps its value across the clock edge.
- R5: With `rule_i` = 2'b01 and `en_i` high, each cell's next bit is own XOR upper XOR left.
- R6: With `rule_i` = 2'b00 or 2'b11 and `en_i` high, each cell's next bit is own XOR (upper OR left). This is the preferred rule.
- R7: With `rule_i` = 2'b10 and `en_i` high, each cell's next bit is own XOR (upper OR NOT left).
- R8: The upper neighbour of (r,c) is ((r-1) mod ROWS, c) and the left neighbour is (r, (c-1) mod COLS). Row 0 therefore reads the last row, and column 0 reads the last column.
- R9: Running rule 2'b10 for a long time from a mixed seed, the fraction of ones over all cells and all cycles lies between 0.15 and 0.85.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the seed into the grid |
| seed_i | input | ROWS*COLS | Seed value, bit r*COLS+c for cell (r,c) |
| en_i | input | 1 | Advance the grid by one step |
| rule_i | input | 2 | Rule select, encoded as in R5 to R7 |
| bits_o | output | ROWS*COLS | Current state bit of every cell |

## Verification
The hardest case to reach is the wrap-around at the grid's edges. A random seed would hide an error in the corner indexing among many other changing bits. The stimulus therefore loads single-hot seeds in the last row and the last column, then takes exactly one step under each rule. Each step moves a lone one across the seam, where a wrong index shows up at once. The zero-seed replacement is reached only by an explicit all-zero load, and that load is followed directly by a step of the XOR rule.

// File: rtl/ca_rng_pkg.sv
package ca_rng_pkg;

  typedef enum logic [1:0] {
    RULE_OR_MIX  = 2'b00,
    RULE_XOR3    = 2'b01,
    RULE_ORN_MIX = 2'b10,
    RULE_ALT_OR  = 2'b11
  } rule_t;

  // Next state of one cell from own (a), upper (b) and left (c) bits.
  function automatic logic cell_next(input rule_t rule, input logic a,
                                     input logic b, input logic c);
    logic nb;
    case (rule)
      RULE_XOR3:    nb = a ^ b ^ c;
      RULE_ORN_MIX: nb = a ^ (b | ~c);
      default:      nb = a ^ (b | c);
    endcase
    return nb;
  endfunction

  // Index one step back along a ring of the given size.
  function automatic int unsigned ring_prev(input int unsigned idx,
                                            input int unsigned size);
    return (idx == 0) ? size - 1 : idx - 1;
  endfunction

endpackage

// File: rtl/ca_seed_sel.sv
module ca_seed_sel #(
  parameter int unsigned NCELL = 32
) (
  input  logic [NCELL-1:0] seed_i,
  output logic [NCELL-1:0] seed_eff_o,
  output logic             seed_zero_o
);
  localparam logic [NCELL-1:0] FILL = {{(NCELL-1){1'b0}}, 1'b1};

  always_comb begin
    seed_zero_o = (seed_i == '0);
    seed_eff_o  = seed_zero_o ? FILL : seed_i;
  end
endmodule

// File: rtl/ca_nbr_map.sv
module ca_nbr_map
  import ca_rng_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8
) (
  input  logic [ROWS*COLS-1:0] grid_i,
  output logic [ROWS*COLS-1:0] up_o,
  output logic [ROWS*COLS-1:0] left_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned SELF = r * COLS + c;
      localparam int unsigned UPI  = ring_prev(r, ROWS) * COLS + c;
      localparam int unsigned LFI  = r * COLS + ring_prev(c, COLS);
      assign up_o[SELF]   = grid_i[UPI];
      assign left_o[SELF] = grid_i[LFI];
    end
  end
endmodule

// File: rtl/ca_cell.sv
module ca_cell
  import ca_rng_pkg::*;
#(
  parameter logic INIT = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  seed_i,
  input  logic  en_i,
  input  rule_t rule_i,
  input  logic  up_i,
  input  logic  left_i,
  output logic  q_o
);
  logic d;

  always_comb begin
    d = q_o;
    if (load_i)    d = seed_i;
    else if (en_i) d = cell_next(rule_i, q_o, up_i, left_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= INIT;
    else        q_o <= d;
  end
endmodule

// File: rtl/ca_rng_array.sv
module ca_rng_array
  import ca_rng_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [ROWS*COLS-1:0] seed_i,
  input  logic                 en_i,
  input  logic [1:0]           rule_i,
  output logic [ROWS*COLS-1:0] bits_o
);
  localparam int unsigned NCELL = ROWS * COLS;

  logic [NCELL-1:0] seed_eff;
  logic             seed_is_zero;
  logic [NCELL-1:0] up_v;
  logic [NCELL-1:0] left_v;
  logic [NCELL-1:0] grid;
  logic             step_fire;
  rule_t            rule;

  assign rule      = rule_t'(rule_i);
  assign step_fire = en_i & ~load_i;

  ca_seed_sel #(.NCELL(NCELL)) u_seed (
    .seed_i     (seed_i),
    .seed_eff_o (seed_eff),
    .seed_zero_o(seed_is_zero)
  );

  ca_nbr_map #(.ROWS(ROWS), .COLS(COLS)) u_nbr (
    .grid_i(grid),
    .up_o  (up_v),
    .left_o(left_v)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    ca_cell #(.INIT(i == 0 ? 1'b1 : 1'b0)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(load_i),
      .seed_i(seed_eff[i]),
      .en_i  (en_i),
      .rule_i(rule),
      .up_i  (up_v[i]),
      .left_i(left_v[i]),
      .q_o   (grid[i])
    );
  end

  assign bits_o = grid;
endmodule

// File: rtl/ca_rng_checker.sv
module ca_rng_checker #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load_i,
  input logic [ROWS*COLS-1:0] seed_i,
  input logic                 en_i,
  input logic [1:0]           rule_i,
  input logic [ROWS*COLS-1:0] bits_o,
  input logic                 seed_is_zero,
  input logic                 step_fire
);
  localparam int unsigned N = ROWS * COLS;
  localparam logic [N-1:0] FILL = {{(N-1){1'b0}}, 1'b1};

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !en_i) |=> $stable(bits_o)); // R4

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !seed_is_zero) |=> bits_o == $past(seed_i)); // R2

  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && seed_i == '0) |=> bits_o == FILL); // R3

  AST_XOR_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && rule_i == 2'b01) |=>
      bits_o[0] == ($past(bits_o[0]) ^ $past(bits_o[(ROWS-1)*COLS]) ^ $past(bits_o[COLS-1]))); // R5

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> bits_o != '0); // R3
endmodule

bind ca_rng_array ca_rng_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i), .en_i(en_i),
  .rule_i(rule_i), .bits_o(bits_o), .seed_is_zero(seed_is_zero),
  .step_fire(step_fire)
);

// File: tb/ca_rng_array_bench.sv
`timescale 1ns/1ps
module ca_rng_array_bench;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int N = ROWS * COLS;

  logic clk = 0;
  logic rst_n = 0;
  logic load_i = 0;
  logic [N-1:0] seed_i = '0;
  logic en_i = 0;
  logic [1:0] rule_i = 2'b00;
  logic [N-1:0] bits_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit model [N];
  longint ones = 0;
  longint samples = 0;

  always #2.5 clk = ~clk;

  ca_rng_array #(.ROWS(ROWS), .COLS(COLS)) u_ca_rng_array (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
    .en_i(en_i), .rule_i(rule_i), .bits_o(bits_o)
  );

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc > 150000);
    bad++;
    $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic bit rule_eval(input logic [1:0] r, input bit a, input bit u, input bit l);
    if (r == 2'b01) return a ^ u ^ l;
    if (r == 2'b10) return (u || !l) ? !a : a;
    return (u || l) ? !a : a;
  endfunction

  task automatic compare(input string tag);
    logic [N-1:0] exp;
    for (int k = 0; k < N; k++) exp[k] = model[k];
    total++;
    if (bits_o !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, bits_o, exp);
    end
  endtask

  // One clock: drive at negedge, update model, compare after edge.
  task automatic tick(input bit ld, input logic [N-1:0] sd, input bit en,
                      input logic [1:0] r, input string tag);
    bit nxt [N];
    @(negedge clk);
    load_i = ld; seed_i = sd; en_i = en; rule_i = r;
    if (ld) begin
      for (int k = 0; k < N; k++) nxt[k] = (sd == 0) ? (k == 0) : sd[k];
    end else if (en) begin
      for (int row = 0; row < ROWS; row++)
        for (int col = 0; col < COLS; col++) begin
          int up_row = (row + ROWS - 1) % ROWS;
          int lf_col = (col + COLS - 1) % COLS;
          nxt[row*COLS+col] = rule_eval(r, model[row*COLS+col],
                                        model[up_row*COLS+col],
                                        model[row*COLS+lf_col]);
        end
    end else begin
      for (int k = 0; k < N; k++) nxt[k] = model[k];
    end
    @(posedge clk); #1;
    for (int k = 0; k < N; k++) model[k] = nxt[k];
    compare(tag);
  endtask

  initial begin
    for (int k = 0; k < N; k++) model[k] = (k == 0);
    repeat (3) @(posedge clk);
    #1 compare("R1 reset pattern");
    @(negedge clk) rst_n = 1;
    #1 compare("R1 after release");

    tick(1, 32'hA5C3_0F96, 1, 2'b01, "R2 load beats enable");
    tick(0, '0, 0, 2'b01, "R4 hold");
    tick(0, 32'hFFFF_FFFF, 0, 2'b10, "R4 hold ignores seed");
    tick(1, '0, 0, 2'b00, "R3 zero seed replaced");
    tick(0, '0, 1, 2'b01, "R5 xor step from fill");

    // R8 wrap: lone one in bottom-left corner, one step per rule
    tick(1, 32'h0100_0000, 0, 2'b00, "R2 corner seed");
    tick(0, '0, 1, 2'b01, "R8 R5 wrap rows xor");
    tick(1, 32'h0000_0080, 0, 2'b00, "R2 right column seed");
    tick(0, '0, 1, 2'b00, "R8 R6 wrap columns or-mix");
    tick(1, 32'h8000_0000, 0, 2'b00, "R2 last cell seed");
    tick(0, '0, 1, 2'b10, "R8 R7 wrap or-not mix");

    for (int i = 0; i < 6; i++) tick(0, '0, 1, 2'b00, "R6 rule 00");
    for (int i = 0; i < 6; i++) tick(0, '0, 1, 2'b11, "R6 rule 11");
    for (int i = 0; i < 6; i++) tick(0, '0, 1, 2'b01, "R5 rule 01");
    for (int i = 0; i < 6; i++) tick(0, '0, 1, 2'b10, "R7 rule 10");
    tick(0, '0, 0, 2'b10, "R4 hold after steps");

    tick(1, 32'h3C5A_96E1, 0, 2'b10, "R2 mixed seed");
    for (int i = 0; i < 3000; i++) begin
      tick(0, '0, 1, 2'b10, "R7 long run");
      ones += $countones(bits_o);
      samples += N;
    end
    total++;
    if (ones * 100 < samples * 15 || ones * 100 > samples * 85) begin
      bad++;
      $display("FAIL R9 ones fraction: actual=%0d/%0d expected 15%%..85%%", ones, samples);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule